// File: doc/BRIEF.md
# Subcode Packet Assembler and Packer

This block sits behind a subcode symbol detector. It receives two kinds of event: a data symbol (an 8-bit value whose top bit is the leading one) and a sync event that reports how many sync symbols the detector inferred from a pause. From these events it rebuilds the 98-symbol packet structure, which is two sync symbols followed by 96 payload symbols. It rides through the occasional symbol that is corrupted into the wrong kind.

Payload symbols are packed four at a time into a 32-bit user word. The bit at position 6 of every payload symbol is also gathered, 32 at a time, into a Q word. Each word has a full flag that works as an interrupt and stays set until software pulses the matching clear input. A sticky overrun bit records any word that completes while its flag is still set.

Both input streams are valid-only. The detector cannot be stalled, so the block has no ready signal and takes every event in the cycle its valid is high. When `sym_valid` and `sync_valid` are high together, the data symbol is taken and the sync event is dropped. The word outputs are read-only and change only on a completion.

Top module: `subcode_assembler`

## Requirements
- R1: After reset the block hunts and ignores data symbols. A sync event with count 2 starts a packet, and the next 96 data symbols are payload indices 0 to 95.
- R2: The 4th, 8th, … 96th payload symbols each load `u_word` with the last four payload symbols, the earliest in bits 31:24, and set `u_full` one clock later.
- R3: `q_word` collects bit 6 of each payload symbol, the earliest in bit 31. It loads after payload indices 31, 63 and 95 and sets `q_full`.
- R4: Every Q load happens in the same cycle as a user load. Grouping restarts at index 0 of each packet, so `q_full` rises only together with the 8th, 16th and 24th user load of a packet.
- R5: In the gap after index 95, a sync event of count 1 plus one data symbol, in either order, counts as the two sync symbols. That data symbol is not packed.
- R6: A gap that collects more than two sync slots before a data symbol is an inconsistent boundary, and the packet still starts. A consistent boundary clears the inconsistency history. A second inconsistent boundary in a row returns the block to hunting: the data symbol that closes it and all later data are not packed until the next count-2 sync event.
- R7: A sync event with a nonzero count inside a packet (index below 96) stands for one corrupted data symbol. A zero symbol is packed in its place and the index advances by one. A count of 0 has no effect anywhere.
- R8: A full flag stays set until its clear input is high in a cycle with no new load. A clear in the same cycle as a load leaves the flag set and raises no overrun.
- R9: A load while the flag is set and not being cleared sets the overrun bit (`u_ovr` or `q_ovr`), and the word still takes the new data. A clear also clears the overrun bit.
- R10: Reset (`rst_n` low) clears both words, both flags and both overrun bits, and puts the block into hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Data symbol event |
| sym_data | input | 8 | Data symbol, bit 7 is the leading one |
| sync_valid | input | 1 | Sync event |
| sync_cnt | input | 2 | Number of inferred sync symbols (0 to 3) |
| u_clr | input | 1 | Clears `u_full` and `u_ovr` |
| q_clr | input | 1 | Clears `q_full` and `q_ovr` |
| u_word | output | 32 | Last four payload symbols |
| u_full | output | 1 | User word full interrupt |
| u_ovr | output | 1 | User word overrun |
| q_word | output | 32 | Last 32 Q bits |
| q_full | output | 1 | Q word full interrupt |
| q_ovr | output | 1 | Q word overrun |

## Verification
Losing lock is the hardest situation to reach from the ports. It needs two inconsistent packet boundaries in a row, and a consistent boundary in between must clear the history. The bench walks a table of whole packets, each tagged with how its boundary is formed: a clean pair of syncs, a corrupted sync slot in either order, or an excess sync. The table orders them so that a reset of the history is seen first and the drop second, followed by a relock. Directed sequences then place a sync inside a packet and drive clears that land on a load or arrive too late.

// File: rtl/subcode_pkg.sv
package subcode_pkg;
  localparam int SYM_W   = 8;
  localparam int PAYLOAD = 96;
  localparam int IDX_W   = $clog2(PAYLOAD + 1);
  localparam int Q_POS   = 6;
  localparam int U_GROUP = 4;
  localparam int Q_GROUP = 32;

  typedef enum logic {
    FR_HUNT  = 1'b0,
    FR_TRACK = 1'b1
  } frame_e;
endpackage

// File: rtl/sc_framer.sv
module sc_framer
  import subcode_pkg::*;
#(
  parameter int SW    = SYM_W,
  parameter int NPAY  = PAYLOAD,
  parameter int IW    = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  input  logic [SW-1:0] sym_data,
  input  logic          sync_valid,
  input  logic [1:0]    sync_cnt,
  output logic          put_valid,
  output logic [SW-1:0] put_data,
  output logic [IW-1:0] put_idx
);
  localparam logic [IW-1:0] GAP_IDX = IW'(NPAY);

  frame_e        st, st_n;
  logic [IW-1:0] idx, idx_n;
  logic [1:0]    slots, slots_n;
  logic          bad, bad_n;
  logic [2:0]    slot_sum;

  assign slot_sum = {1'b0, slots} + {1'b0, sync_cnt};

  always_comb begin
    st_n      = st;
    idx_n     = idx;
    slots_n   = slots;
    bad_n     = bad;
    put_valid = 1'b0;
    put_data  = '0;
    put_idx   = idx;
    if (st == FR_HUNT) begin
      if (sync_valid && sync_cnt == 2'd2) begin
        st_n  = FR_TRACK;
        idx_n = '0;
        bad_n = 1'b0;
      end
    end else if (idx != GAP_IDX) begin
      slots_n = '0;
      if (sym_valid) begin
        put_valid = 1'b1;
        put_data  = sym_data;
        idx_n     = idx + 1'b1;
      end else if (sync_valid && sync_cnt != 2'd0) begin
        put_valid = 1'b1;
        idx_n     = idx + 1'b1;
      end
    end else begin
      if (sym_valid) begin
        if (slots < 2'd2) begin
          slots_n = slots + 1'b1;
        end else if (slots == 2'd3 && bad) begin
          st_n = FR_HUNT;
        end else begin
          bad_n     = (slots == 2'd3);
          put_valid = 1'b1;
          put_data  = sym_data;
          put_idx   = '0;
          idx_n     = IW'(1);
        end
      end else if (sync_valid) begin
        slots_n = slot_sum[2] ? 2'd3 : slot_sum[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= FR_HUNT;
      idx   <= '0;
      slots <= '0;
      bad   <= 1'b0;
    end else begin
      st    <= st_n;
      idx   <= idx_n;
      slots <= slots_n;
      bad   <= bad_n;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= GAP_IDX); // R1
  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_HUNT) |-> !put_valid); // R6
  AST_PUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    put_valid |-> (put_idx < GAP_IDX)); // R1
endmodule

// File: rtl/sc_packer.sv
module sc_packer #(
  parameter int DW    = 8,
  parameter int GROUP = 4,
  parameter int IW    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               put_valid,
  input  logic [DW-1:0]      put_data,
  input  logic [IW-1:0]      put_idx,
  input  logic               clr,
  output logic [DW*GROUP-1:0] word,
  output logic               full,
  output logic               ovr,
  output logic               loaded
);
  localparam int REG_W = DW * GROUP;
  localparam int ACC_W = REG_W - DW;

  logic [ACC_W-1:0] acc;
  logic [REG_W-1:0] ext;

  assign ext    = {acc, put_data};
  assign loaded = put_valid && ((put_idx % IW'(GROUP)) == IW'(GROUP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      word <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (put_valid) acc <= ext[ACC_W-1:0];
      if (loaded) word <= ext;
      if (loaded) full <= 1'b1;
      else if (clr) full <= 1'b0;
      if (loaded && full && !clr) ovr <= 1'b1;
      else if (clr) ovr <= 1'b0;
    end
  end

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full); // R8
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> full); // R2
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(full)); // R9
endmodule

// File: rtl/subcode_assembler.sv
module subcode_assembler
  import subcode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sym_valid,
  input  logic [7:0]  sym_data,
  input  logic        sync_valid,
  input  logic [1:0]  sync_cnt,
  input  logic        u_clr,
  input  logic        q_clr,
  output logic [31:0] u_word,
  output logic        u_full,
  output logic        u_ovr,
  output logic [31:0] q_word,
  output logic        q_full,
  output logic        q_ovr
);
  logic             put_valid;
  logic [SYM_W-1:0] put_data;
  logic [IDX_W-1:0] put_idx;
  logic             u_loaded, q_loaded;

  sc_framer #(.SW(SYM_W), .NPAY(PAYLOAD), .IW(IDX_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .sym_valid(sym_valid), .sym_data(sym_data),
    .sync_valid(sync_valid), .sync_cnt(sync_cnt),
    .put_valid(put_valid), .put_data(put_data), .put_idx(put_idx)
  );

  sc_packer #(.DW(SYM_W), .GROUP(U_GROUP), .IW(IDX_W)) u_upack (
    .clk(clk), .rst_n(rst_n),
    .put_valid(put_valid), .put_data(put_data), .put_idx(put_idx),
    .clr(u_clr), .word(u_word), .full(u_full), .ovr(u_ovr), .loaded(u_loaded)
  );

  sc_packer #(.DW(1), .GROUP(Q_GROUP), .IW(IDX_W)) u_qpack (
    .clk(clk), .rst_n(rst_n),
    .put_valid(put_valid), .put_data(put_data[Q_POS]), .put_idx(put_idx),
    .clr(q_clr), .word(q_word), .full(q_full), .ovr(q_ovr), .loaded(q_loaded)
  );

  AST_Q_WITH_U: assert property (@(posedge clk) disable iff (!rst_n)
    q_loaded |-> u_loaded); // R4
endmodule

// File: tb/tb_subcode_assembler.sv
module tb_subcode_assembler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym_data = '0;
  logic        sync_valid = 1'b0;
  logic [1:0]  sync_cnt = '0;
  logic        u_clr = 1'b0;
  logic        q_clr = 1'b0;
  logic [31:0] u_word, q_word;
  logic        u_full, u_ovr, q_full, q_ovr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] u_sh = '0;
  logic [31:0] q_sh = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  subcode_assembler dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .sync_valid(sync_valid), .sync_cnt(sync_cnt), .u_clr(u_clr), .q_clr(q_clr),
    .u_word(u_word), .u_full(u_full), .u_ovr(u_ovr),
    .q_word(q_word), .q_full(q_full), .q_ovr(q_ovr)
  );

  // packet table: {boundary kind[1:0], packed[0], seed[7:0]}
  // kind 0: sync 2, kind 1: sync 1 then bad data, kind 2: bad data then sync 1, kind 3: sync 3
  localparam logic [10:0] PKT_TAB [8] = '{
    {2'd0, 1'b1, 8'd11}, {2'd1, 1'b1, 8'd22}, {2'd2, 1'b1, 8'd33},
    {2'd3, 1'b1, 8'd44}, {2'd0, 1'b1, 8'd55}, {2'd3, 1'b1, 8'd66},
    {2'd3, 1'b0, 8'd77}, {2'd0, 1'b1, 8'd88}
  };

  function automatic logic [7:0] gen(input int s, input int i);
    return {1'b1, 7'(s * 5 + i * 29 + (i >> 2))};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_sym(input logic [7:0] d, input logic cu, input logic cq);
    @(negedge clk);
    sym_valid = 1'b1; sym_data = d; u_clr = cu; q_clr = cq;
    @(negedge clk);
    sym_valid = 1'b0; u_clr = 1'b0; q_clr = 1'b0;
  endtask

  task automatic send_sync(input logic [1:0] c);
    @(negedge clk);
    sync_valid = 1'b1; sync_cnt = c;
    @(negedge clk);
    sync_valid = 1'b0; sync_cnt = '0;
  endtask

  task automatic pulse_clr(input logic cu, input logic cq);
    @(negedge clk);
    u_clr = cu; q_clr = cq;
    @(negedge clk);
    u_clr = 1'b0; q_clr = 1'b0;
  endtask

  task automatic model_put(input logic [7:0] d);
    u_sh = {u_sh[23:0], d};
    q_sh = {q_sh[30:0], d[6]};
  endtask

  task automatic chk_reset_state(input string tag);
    chk(u_word, 32'h0, tag); chk(q_word, 32'h0, tag);
    chk({28'h0, u_full, u_ovr, q_full, q_ovr}, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R10 reset");

    // data while hunting is ignored
    for (int i = 0; i < 4; i++) send_sym(gen(1, i), 1'b0, 1'b0);
    chk({31'h0, u_full}, 32'h0, "R1 hunt ignores data");

    for (int e = 0; e < 8; e++) begin
      logic [1:0] kind = PKT_TAB[e][10:9];
      logic       pk   = PKT_TAB[e][8];
      int         seed = int'(PKT_TAB[e][7:0]);
      string      lbl  = (kind == 2'd0) ? "R1" : (kind == 2'd3 ? "R6" : "R5");
      case (kind)
        2'd0: send_sync(2'd2);
        2'd1: begin send_sync(2'd1); send_sym(8'h8F, 1'b0, 1'b0); end
        2'd2: begin send_sym(8'hC3, 1'b0, 1'b0); send_sync(2'd1); end
        default: send_sync(2'd3);
      endcase
      for (int i = 0; i < 96; i++) begin
        logic [7:0] d = gen(seed, i);
        send_sym(d, 1'b0, 1'b0);
        if (pk) begin
          model_put(d);
          if (i % 4 == 3) begin
            chk({31'h0, u_full}, 32'h1, $sformatf("R2 %s flag pkt %0d", lbl, e));
            chk(u_word, u_sh, $sformatf("R2 %s word pkt %0d", lbl, e));
            if (i % 32 == 31) begin
              chk({31'h0, q_full}, 32'h1, $sformatf("R4 q flag pkt %0d", e));
              chk(q_word, q_sh, $sformatf("R3 q word pkt %0d", e));
            end else begin
              chk({31'h0, q_full}, 32'h0, $sformatf("R4 no q flag pkt %0d", e));
            end
            pulse_clr(1'b1, 1'b1);
          end
        end else if (i % 4 == 3) begin
          chk({31'h0, u_full}, 32'h0, $sformatf("R6 dropped lock pkt %0d", e));
        end
      end
    end

    // mid-packet sync stands for one zero symbol
    send_sync(2'd2);
    for (int i = 0; i < 3; i++) begin
      send_sym(gen(9, i), 1'b0, 1'b0); model_put(gen(9, i));
    end
    send_sync(2'd1); model_put(8'h00);
    chk(u_word, u_sh, "R7 zero substitute");
    chk({31'h0, u_full}, 32'h1, "R7 flag");
    pulse_clr(1'b1, 1'b0);

    // overrun on user word
    for (int i = 4; i < 8; i++) begin
      send_sym(gen(9, i), 1'b0, 1'b0); model_put(gen(9, i));
    end
    repeat (3) @(negedge clk);
    chk({31'h0, u_full}, 32'h1, "R8 flag held");
    for (int i = 8; i < 12; i++) begin
      send_sym(gen(9, i), 1'b0, 1'b0); model_put(gen(9, i));
    end
    chk({31'h0, u_ovr}, 32'h1, "R9 overrun set");
    chk(u_word, u_sh, "R9 word takes new data");
    pulse_clr(1'b1, 1'b0);
    chk({30'h0, u_full, u_ovr}, 32'h0, "R9 clear drops flag and overrun");

    // clear coinciding with a load
    for (int i = 12; i < 15; i++) begin
      send_sym(gen(9, i), 1'b0, 1'b0); model_put(gen(9, i));
    end
    send_sym(gen(9, 15), 1'b1, 1'b0); model_put(gen(9, 15));
    chk({30'h0, u_full, u_ovr}, 32'h2, "R8 clear on load keeps flag");
    pulse_clr(1'b1, 1'b0);

    // Q overrun, never clearing Q
    for (int i = 16; i < 64; i++) begin
      send_sym(gen(9, i), 1'b0, 1'b0); model_put(gen(9, i));
      if (i == 31) begin
        chk({31'h0, q_full}, 32'h1, "R3 q full");
        chk(q_word, q_sh, "R3 q word");
      end
      if (i == 63) begin
        chk({30'h0, q_full, q_ovr}, 32'h3, "R9 q overrun");
        chk(q_word, q_sh, "R9 q word new data");
      end
      if (i % 4 == 3) pulse_clr(1'b1, 1'b0);
    end

    // reset mid-stream
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R10 mid-run reset");
    for (int i = 0; i < 4; i++) send_sym(gen(2, i), 1'b0, 1'b0);
    chk({31'h0, u_full}, 32'h0, "R10 hunting after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule